// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a small synchronous static memory with four byte lanes. Every control input is sampled on the rising clock edge. The exceptions are the output enable and the sleep input, which act without waiting for a clock. An access starts when one of two start strobes loads an external address into the block. After that, a 2-bit burst counter can produce three more addresses inside the aligned group of four words. The counter moves in either wrapping linear order or XOR-interleaved order. A new address may be loaded on any cycle, so bursts are optional.

The memory is flow-through. Once the clock edge has sampled an address, the read word appears on the output during the cycle that follows, with no output register. The read data leaves the block as a stream with a valid flag only:
- `rvalid` high means `rdata` holds the addressed word for that cycle.
- There is no ready input, so the consumer must take the word in the cycle it is offered.
- `rdata` is zero whenever `rvalid` is low. This stands in for a released bus.

Writes take the word on `wdata` at the edge that samples the write command. The write can cover selected byte lanes or all lanes at once.

Top module: `fsb_sram_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, no access is active: `rvalid` is 0 and `rdata` is 0 until a start strobe is accepted.
- R2: With the chip selected (`ce0_n`=0, `ce1`=1, `ce2_n`=0), `ld_ctl_n`=0 loads `addr`. For a read, the word at `addr` is on `rdata` with `rvalid`=1 in the cycle after that edge. For a write, `wdata` is stored at that edge and `rvalid` stays 0 in the following cycle.
- R3: `ld_ctl_n` acts whatever `ce0_n` is, and it wins when both start strobes are low, so its write controls are obeyed. If the chip is not selected on an `ld_ctl_n` cycle, the access ends and `rvalid` goes to 0.
- R4: `ld_cpu_n`=0 is obeyed only when `ce0_n`=0, and it always starts a read, ignoring all write controls. When `ce0_n`=1 the strobe has no effect and the current access keeps its address.
- R5: During an active access, with no start strobe, `step_n`=0 advances the 2-bit burst count by one. `step_n`=1 keeps the same address.
- R6: With `seq_linear`=1, beat k of a burst from address A uses low bits (A[1:0]+k) mod 4. Bits above bit 1 are unchanged.
- R7: With `seq_linear`=0, beat k uses low bits A[1:0] XOR k. Bits above bit 1 are unchanged.
- R8: `wr_all_n`=0 writes all four lanes, regardless of `wr_lane_n` and `lane_n`.
- R9: With `wr_all_n`=1 and `wr_lane_n`=0, only lanes i with `lane_n[i]`=0 are written, from `wdata[8i+7:8i]`. Other lanes keep their contents. With both write controls high, the cycle is a read and nothing is written.
- R10: `out_en_n`=1 forces `rvalid` to 0 and `rdata` to 0 at once, without clock or state change. Clearing it brings the word back at once.
- R11: While `sleep`=1, clock edges change neither contents nor access state, and `rvalid` is 0. After `sleep` falls, the same address is presented with its old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | 6 | External word address |
| ce0_n | input | 1 | Chip enable, active low; also gates `ld_cpu_n` |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| ld_cpu_n | input | 1 | Read-only start strobe, active low |
| ld_ctl_n | input | 1 | Priority start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| seq_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_n | input | 1 | Enable per-lane writes, active low |
| lane_n | input | 4 | Per-lane write select, active low |
| wdata | input | 32 | Write word |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, active high, asynchronous |
| rdata | output | 32 | Read word, zero when not valid |
| rvalid | output | 1 | Read word valid this cycle |

## Verification
The hardest state to reach is an interleaved burst whose start offset is not zero. It must be observed beat by beat, with the upper address bits held, while a write-enabled continuation runs under the same counter. The bench loads start addresses with every low-bit offset in several aligned groups, in both orders. It writes whole bursts through step cycles and reads each beat back with single loads. It also sets up collisions that show no effect on their own, such as a gated start strobe, a write request on a read-only start, or a write during sleep. Each of these is made visible by re-reading the held address at the output.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2,
    CMD_HOLD = 2'd3
  } addr_cmd_e;
endpackage

// File: rtl/fsb_burst_addr.sv
module fsb_burst_addr
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  addr_cmd_e         cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              linear,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] q_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [1:0] c,
                                                  input logic lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
    return {b[ADDR_W-1:2], lo};
  endfunction

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    case (cmd)
      CMD_LOAD: begin
        base_d = ext_addr;
        cnt_d  = 2'd0;
      end
      CMD_STEP: cnt_d = cnt_q + 2'd1;
      default: ;
    endcase
  end

  assign acc_addr = beat_addr(base_d, cnt_d, linear);
  assign q_addr   = beat_addr(base_q, cnt_q, linear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd == CMD_STEP) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd == CMD_LOAD) |=> (q_addr == $past(ext_addr)));
endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce0_n,
  input  logic             ce1,
  input  logic             ce2_n,
  input  logic             ld_cpu_n,
  input  logic             ld_ctl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             sleep,
  output addr_cmd_e        cmd,
  output logic [LANES-1:0] lane_we,
  output logic             active_q,
  output logic             rd_q
);
  logic             sel;
  logic [LANES-1:0] wr_mask;
  logic             is_wr;
  logic             active_d, rd_d;
  addr_cmd_e        cmd_raw;
  logic [LANES-1:0] we_raw;

  assign sel = !ce0_n && ce1 && !ce2_n;

  always_comb begin
    if (!wr_all_n)       wr_mask = {LANES{1'b1}};
    else if (!wr_lane_n) wr_mask = ~lane_n;
    else                 wr_mask = '0;
  end
  assign is_wr = |wr_mask;

  always_comb begin
    cmd_raw  = CMD_IDLE;
    active_d = active_q;
    rd_d     = rd_q;
    we_raw   = '0;
    if (!ld_ctl_n) begin
      if (sel) begin
        cmd_raw  = CMD_LOAD;
        active_d = 1'b1;
        rd_d     = !is_wr;
        we_raw   = wr_mask;
      end else begin
        active_d = 1'b0;
        rd_d     = 1'b0;
      end
    end else if (!ld_cpu_n && !ce0_n) begin
      if (sel) begin
        cmd_raw  = CMD_LOAD;
        active_d = 1'b1;
        rd_d     = 1'b1;
      end else begin
        active_d = 1'b0;
        rd_d     = 1'b0;
      end
    end else if (active_q) begin
      cmd_raw = step_n ? CMD_HOLD : CMD_STEP;
      rd_d    = !is_wr;
      we_raw  = wr_mask;
    end
  end

  assign cmd     = sleep ? CMD_IDLE : cmd_raw;
  assign lane_we = sleep ? '0 : we_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else if (!sleep) begin
      active_q <= active_d;
      rd_q     <= rd_d;
    end
  end

  // R11
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(active_q) && $stable(rd_q)));
endmodule

// File: rtl/fsb_lane_mem.sv
module fsb_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fsb_sram_top.sv
module fsb_sram_top
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce0_n,
  input  logic                    ce1,
  input  logic                    ce2_n,
  input  logic                    ld_cpu_n,
  input  logic                    ld_ctl_n,
  input  logic                    step_n,
  input  logic                    seq_linear,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  addr_cmd_e         cmd;
  logic [LANES-1:0]  lane_we;
  logic              active_q, rd_q;
  logic [ADDR_W-1:0] acc_addr, q_addr;
  logic [DATA_W-1:0] word;
  logic              sel_seen;

  fsb_ctrl #(.LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_n(lane_n),
    .sleep(sleep), .cmd(cmd), .lane_we(lane_we),
    .active_q(active_q), .rd_q(rd_q)
  );

  fsb_burst_addr #(.ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .en(!sleep), .cmd(cmd),
    .ext_addr(addr), .linear(seq_linear),
    .acc_addr(acc_addr), .q_addr(q_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fsb_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) mem_i (
      .clk(clk),
      .we(lane_we[g]),
      .waddr(acc_addr),
      .wdata(wdata[g*LANE_W +: LANE_W]),
      .raddr(q_addr),
      .rdata(word[g*LANE_W +: LANE_W])
    );
  end

  assign rvalid = active_q && rd_q && !out_en_n && !sleep;
  assign rdata  = rvalid ? word : '0;

  assign sel_seen = !ce0_n && ce1 && !ce2_n;

  // R8
  global_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ld_ctl_n && sel_seen && !wr_all_n) |-> (lane_we == {LANES{1'b1}}));

  // R4
  cpu_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && ld_ctl_n && !ce0_n) |-> (lane_we == '0));

  // R9
  no_wr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all_n && wr_lane_n) |-> (lane_we == '0));
endmodule

// File: tb/fsb_sram_top_tb_top.sv
module fsb_sram_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        ce0_n, ce1, ce2_n;
  logic        ld_cpu_n, ld_ctl_n, step_n, seq_linear;
  logic        wr_all_n, wr_lane_n;
  logic [3:0]  lane_n;
  logic [31:0] wdata;
  logic        out_en_n, sleep;
  logic [31:0] rdata;
  logic        rvalid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ref_mem [64];

  always #10 clk = ~clk;

  fsb_sram_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n),
    .seq_linear(seq_linear), .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n),
    .lane_n(lane_n), .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
    .rdata(rdata), .rvalid(rvalid)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic rel();
    ld_cpu_n = 1'b1; ld_ctl_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; wr_lane_n = 1'b1; lane_n = 4'hF;
    ce0_n = 1'b0; ce1 = 1'b1; ce2_n = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int s);
    return 32'(a * 16777619 + s * 40503 + 32'h5A17C3E1);
  endfunction

  function automatic int beat(input int base, input int k, input bit lin);
    int lo;
    lo = lin ? ((base + k) & 3) : ((base & 3) ^ k);
    return (base & ~3) | lo;
  endfunction

  task automatic ref_wr(input int a, input logic [3:0] m, input logic [31:0] d);
    for (int i = 0; i < 4; i++)
      if (m[i]) ref_mem[a][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic ctl_write_all(input int a, input logic [31:0] d);
    addr = 6'(a); ld_ctl_n = 1'b0; wr_all_n = 1'b0; wdata = d;
    tick();
    rel();
    ref_wr(a, 4'hF, d);
  endtask

  task automatic ctl_read(input string tag, input int a);
    addr = 6'(a); ld_ctl_n = 1'b0;
    tick();
    rel();
    chk({tag, " rvalid"}, 32'(rvalid), 32'd1);
    chk(tag, rdata, ref_mem[a]);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; seq_linear = 1'b0;
    out_en_n = 1'b0; sleep = 1'b0;
    rel();
    repeat (3) tick();
    // R1: reset state
    chk("R1 rvalid in reset", 32'(rvalid), 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 rvalid after reset", 32'(rvalid), 32'd0);

    // R2 / R8: fill all words with single global writes
    for (int a = 0; a < 64; a++) begin
      ctl_write_all(a, pat(a, 1));
      chk("R2 no rvalid on write", 32'(rvalid), 32'd0);
    end
    for (int a = 0; a < 64; a++) ctl_read("R2 single read", a);

    // R6 / R7: read bursts, both orders, every start offset
    for (int lin = 0; lin < 2; lin++) begin
      for (int blk = 0; blk < 16; blk += 5) begin
        for (int off = 0; off < 4; off++) begin
          int base;
          base = blk * 4 + off;
          seq_linear = 1'(lin);
          addr = 6'(base); ld_cpu_n = 1'b0;
          tick();
          rel();
          chk(lin ? "R6 beat0" : "R7 beat0", rdata, ref_mem[beat(base, 0, lin[0])]);
          for (int k = 1; k < 4; k++) begin
            step_n = 1'b0;
            tick();
            rel();
            chk(lin ? "R6 linear beat" : "R7 interleaved beat",
                rdata, ref_mem[beat(base, k, lin[0])]);
          end
          // R5: hold keeps the last address
          tick();
          chk("R5 hold", rdata, ref_mem[beat(base, 3, lin[0])]);
        end
      end
    end

    // R5 / R6 / R7: write bursts through step cycles, then read back
    for (int lin = 0; lin < 2; lin++) begin
      for (int off = 0; off < 4; off++) begin
        int base;
        base = 48 + lin * 8 + off;
        seq_linear = 1'(lin);
        addr = 6'(base); ld_ctl_n = 1'b0; wr_all_n = 1'b0;
        wdata = pat(base, 7 + off);
        tick();
        ref_wr(beat(base, 0, lin[0]), 4'hF, wdata);
        ld_ctl_n = 1'b1;
        for (int k = 1; k < 4; k++) begin
          step_n = 1'b0; wr_all_n = 1'b0; wdata = pat(base + k, 9 + off);
          tick();
          ref_wr(beat(base, k, lin[0]), 4'hF, wdata);
        end
        rel();
        for (int k = 0; k < 4; k++)
          ctl_read(lin ? "R6 write burst readback" : "R7 write burst readback",
                   beat(base, k, lin[0]));
      end
    end
    seq_linear = 1'b0;

    // R9: every lane mask on words 16..31
    for (int m = 0; m < 16; m++) begin
      addr = 6'(16 + m); ld_ctl_n = 1'b0; wr_lane_n = 1'b0;
      lane_n = ~4'(m); wdata = pat(m, 99);
      tick();
      rel();
      ref_wr(16 + m, 4'(m), pat(m, 99));
    end
    for (int m = 0; m < 16; m++) ctl_read("R9 lane write", 16 + m);

    // R9: both write controls high -> read, no write
    addr = 6'd20; ld_ctl_n = 1'b0; lane_n = 4'h0; wdata = 32'hDEADBEEF;
    tick();
    rel();
    chk("R9 no-write cycle reads", rdata, ref_mem[20]);
    ctl_read("R9 word untouched", 20);

    // R8: global write overrides lane controls
    addr = 6'd21; ld_ctl_n = 1'b0; wr_all_n = 1'b0; wr_lane_n = 1'b1;
    lane_n = 4'hF; wdata = 32'hC0FFEE11;
    tick();
    rel();
    ref_wr(21, 4'hF, 32'hC0FFEE11);
    ctl_read("R8 global override", 21);

    // R3: both strobes low -> priority strobe, write honored
    addr = 6'd22; ld_ctl_n = 1'b0; ld_cpu_n = 1'b0; wr_all_n = 1'b0;
    wdata = 32'h12345678;
    tick();
    rel();
    ref_wr(22, 4'hF, 32'h12345678);
    chk("R3 priority write no rvalid", 32'(rvalid), 32'd0);
    ctl_read("R3 priority write", 22);

    // R4: read-only start ignores write request
    addr = 6'd23; ld_cpu_n = 1'b0; wr_all_n = 1'b0; wdata = 32'hBAD0BAD0;
    tick();
    rel();
    chk("R4 cpu start rvalid", 32'(rvalid), 32'd1);
    chk("R4 cpu start read data", rdata, ref_mem[23]);
    ctl_read("R4 word kept", 23);

    // R4: gated by ce0_n -> no effect, access held
    ctl_read("R4 setup", 10);
    addr = 6'd40; ld_cpu_n = 1'b0; ce0_n = 1'b1;
    tick();
    rel();
    chk("R4 gated strobe holds address", rdata, ref_mem[10]);

    // R3: priority strobe with ce0_n high acts and deselects
    addr = 6'd40; ld_ctl_n = 1'b0; ce0_n = 1'b1;
    tick();
    rel();
    chk("R3 deselect via ce0_n", 32'(rvalid), 32'd0);
    ctl_read("R3 reselect", 11);
    addr = 6'd12; ld_ctl_n = 1'b0; ce1 = 1'b0;
    tick();
    rel();
    chk("R3 deselect via ce1", 32'(rvalid), 32'd0);

    // R10: output enable acts immediately
    ctl_read("R10 setup", 30);
    out_en_n = 1'b1;
    #1;
    chk("R10 rvalid off", 32'(rvalid), 32'd0);
    chk("R10 rdata zero", rdata, 32'd0);
    out_en_n = 1'b0;
    #1;
    chk("R10 rdata back", rdata, ref_mem[30]);
    tick();

    // R11: sleep blocks a write and keeps state
    ctl_read("R11 setup", 31);
    sleep = 1'b1;
    #1;
    chk("R11 rvalid in sleep", 32'(rvalid), 32'd0);
    addr = 6'd31; ld_ctl_n = 1'b0; wr_all_n = 1'b0; wdata = 32'h0BADF00D;
    tick();
    addr = 6'd5; ld_ctl_n = 1'b0;
    tick();
    rel();
    sleep = 1'b0;
    #1;
    chk("R11 rvalid after sleep", 32'(rvalid), 32'd1);
    chk("R11 same word after sleep", rdata, ref_mem[31]);
    tick();
    ctl_read("R11 contents kept", 31);

    finish_run();
  end
endmodule